// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block is the controller-side sequencer that loads the two mode registers of a DDR SDRAM. It waits for a start pulse, checks the requested CAS latency and burst length, and then drives the command pins, the bank address and the row address through a fixed program. That program is a precharge of all banks, then the extended register (DLL enable, drive strength), then the base register (burst length, burst type, CAS latency, DLL reset). The spacing between commands is set in clock cycles by parameters. Every cycle that carries no command is a NOP.

The configuration is captured when the start pulse is accepted, so the inputs may change while a sequence runs. A configuration with no legal encoding sets an error flag and issues no command. A completed sequence leaves a done level that holds until the next start.

Top module: `ddr_mrs_seq`

## Requirements
- R1: After reset the outputs show a NOP (cs_no=0, ras_no=1, cas_no=1, we_no=1), ba_o=0, addr_o=0, and busy_o, done_o and err_o are all 0.
- R2: The precharge-all command is cs_no=0, ras_no=0, cas_no=1, we_no=0 with addr_o[10]=1, all other address bits 0 and ba_o=0. It appears in the first output cycle after an accepted start. A mode write is all four command pins low.
- R3: An accepted start gives, in this order: one precharge-all, one extended-register write (ba_o=01), one base-register write (ba_o=00), and then done.
- R4: The extended write is issued exactly max(TRP_CYC,1) cycles after the precharge-all, with NOPs in between.
- R5: The base write comes exactly max(TMRD_CYC,2) cycles after the extended write. done_o rises the same number of cycles after the base write. Only NOPs are issued in between.
- R6: The base word is as follows. addr_o[2:0] is the burst length code (2→001, 4→010, 8→011). addr_o[3] is 1 for interleaved bursts. addr_o[6:4] is the CAS latency code. Latency is given on cas_half_i in half cycles: 4 (2.0)→010, 5 (2.5)→110, 6 (3.0)→011. addr_o[7]=0, addr_o[8] is the DLL reset request, and addr_o[12:9]=0.
- R7: The extended word has addr_o[0]=1 to disable the DLL and addr_o[1]=1 for half drive strength. Every other bit is 0.
- R8: A start with cas_half_i outside {4,5,6} or burst_len_i outside {2,4,8} sets err_o and clears done_o in the next cycle. It issues no command and leaves busy_o low. The next legal start clears err_o.
- R9: done_o stays high until a start is accepted and falls in the cycle after it. done_o and busy_o are never both high.
- R10: A start pulse while busy_o is high has no effect on the command stream.
- R11: Configuration inputs are sampled only at an accepted start. Changes later in a sequence do not alter the written words.
- R12: ba_o[1] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| cas_half_i | input | 3 | CAS latency in half cycles |
| burst_len_i | input | 4 | Burst length in beats |
| interleave_i | input | 1 | 1 = interleaved burst order |
| dll_reset_i | input | 1 | Request DLL reset in base word |
| dll_disable_i | input | 1 | 1 = disable DLL |
| half_drive_i | input | 1 | 1 = half output drive strength |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, held |
| err_o | output | 1 | Last start had an illegal configuration |

## Verification
The bench sweeps every CAS latency and burst length code together with the interleave and DLL and drive flags. Each cycle's pin state is compared against a timeline computed from the parameters. A design with an off-by-one counter shifts a write by one cycle. A design that does not clamp the tMRD setting places the writes back to back. A design that reads the inputs live writes scrambled words, because the bench changes the inputs and pulses start in the middle of every sequence. Illegal codes must raise the error flag and produce no precharge. Done must survive idle cycles and drop on the next start.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;
  localparam int unsigned ADDR_W = 13;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_EMR,
    ST_MR
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_MRS = 4'b0000;

  localparam logic [1:0] BA_BASE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b01;
endpackage

// File: rtl/ddr_mrs_encode.sv
module ddr_mrs_encode
  import ddr_mrs_pkg::*;
(
  input  logic [2:0]        cas_half_i,
  input  logic [3:0]        burst_len_i,
  input  logic              interleave_i,
  input  logic              dll_reset_i,
  input  logic              dll_disable_i,
  input  logic              half_drive_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] ext_o,
  output logic              ok_o
);
  logic [2:0] cl_code;
  logic [2:0] bl_code;
  logic       cl_ok;
  logic       bl_ok;

  always_comb begin
    cl_ok = 1'b1;
    unique case (cas_half_i)
      3'd4:    cl_code = 3'b010;
      3'd5:    cl_code = 3'b110;
      3'd6:    cl_code = 3'b011;
      default: begin cl_code = 3'b000; cl_ok = 1'b0; end
    endcase
  end

  always_comb begin
    bl_ok = 1'b1;
    unique case (burst_len_i)
      4'd2:    bl_code = 3'b001;
      4'd4:    bl_code = 3'b010;
      4'd8:    bl_code = 3'b011;
      default: begin bl_code = 3'b000; bl_ok = 1'b0; end
    endcase
  end

  always_comb begin
    base_o      = '0;
    base_o[2:0] = bl_code;
    base_o[3]   = interleave_i;
    base_o[6:4] = cl_code;
    base_o[8]   = dll_reset_i;
    ext_o       = '0;
    ext_o[0]    = dll_disable_i;
    ext_o[1]    = half_drive_i;
  end

  assign ok_o = cl_ok & bl_ok;
endmodule

// File: rtl/ddr_mrs_timer.sv
module ddr_mrs_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
  import ddr_mrs_pkg::*;
#(
  parameter int unsigned TRP_CYC  = 3,
  parameter int unsigned TMRD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        cas_half_i,
  input  logic [3:0]        burst_len_i,
  input  logic              interleave_i,
  input  logic              dll_reset_i,
  input  logic              dll_disable_i,
  input  logic              half_drive_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned TRP_EFF  = (TRP_CYC < 1) ? 1 : TRP_CYC;
  localparam int unsigned TMRD_EFF = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int unsigned MAX_WAIT = (TRP_EFF > TMRD_EFF) ? TRP_EFF : TMRD_EFF;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP_EFF - 1);
  localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD_EFF - 1);

  logic [ADDR_W-1:0] base_w, ext_w;
  logic              cfg_ok;

  seq_state_e        state_q, state_d;
  cmd_t              cmd_q, cmd_d;
  logic [1:0]        ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] base_q, base_d, ext_q, ext_d;
  logic              busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;

  ddr_mrs_encode u_encode (
    .cas_half_i   (cas_half_i),
    .burst_len_i  (burst_len_i),
    .interleave_i (interleave_i),
    .dll_reset_i  (dll_reset_i),
    .dll_disable_i(dll_disable_i),
    .half_drive_i (half_drive_i),
    .base_o       (base_w),
    .ext_o        (ext_w),
    .ok_o         (cfg_ok)
  );

  ddr_mrs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    ba_d     = BA_BASE;
    addr_d   = '0;
    base_d   = base_q;
    ext_d    = ext_q;
    busy_d   = busy_q;
    done_d   = done_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          done_d = 1'b0;
          if (cfg_ok) begin
            cmd_d      = CMD_PRE;
            addr_d[10] = 1'b1;  // all banks
            base_d     = base_w;
            ext_d      = ext_w;
            busy_d     = 1'b1;
            err_d      = 1'b0;
            tmr_load   = 1'b1;
            tmr_val    = TRP_LD;
            state_d    = ST_PRE;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (tmr_zero) begin
          cmd_d    = CMD_MRS;
          ba_d     = BA_EXT;
          addr_d   = ext_q;
          tmr_load = 1'b1;
          tmr_val  = TMRD_LD;
          state_d  = ST_EMR;
        end
      end
      ST_EMR: begin
        if (tmr_zero) begin
          cmd_d    = CMD_MRS;
          ba_d     = BA_BASE;
          addr_d   = base_q;
          tmr_load = 1'b1;
          tmr_val  = TMRD_LD;
          state_d  = ST_MR;
        end
      end
      ST_MR: begin
        if (tmr_zero) begin
          busy_d  = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= BA_BASE;
      addr_q  <= '0;
      base_q  <= '0;
      ext_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      base_q  <= base_d;
      ext_q   <= ext_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign cs_no  = cmd_q.cs_n;
  assign ras_no = cmd_q.ras_n;
  assign cas_no = cmd_q.cas_n;
  assign we_no  = cmd_q.we_n;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/ddr_mrs_seq_chk.sv
module ddr_mrs_seq_chk #(
  parameter int unsigned TRP_CYC = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        cs_no,
  input logic        ras_no,
  input logic        cas_no,
  input logic        we_no,
  input logic [1:0]  ba_o,
  input logic [12:0] addr_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  localparam int unsigned TRP_EFF = (TRP_CYC < 1) ? 1 : TRP_CYC;

  logic        is_mrs, is_pre, is_nop;
  logic [31:0] since_pre;
  logic        ext_seen;

  assign is_mrs = !cs_no && !ras_no && !cas_no && !we_no;
  assign is_pre = !cs_no && !ras_no && cas_no && !we_no;
  assign is_nop = !cs_no && ras_no && cas_no && we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre <= '0;
      ext_seen  <= 1'b0;
    end else begin
      if (is_pre)                  since_pre <= 32'd1;
      else if (since_pre != '0 && since_pre != '1) since_pre <= since_pre + 32'd1;
      if (is_pre)                  ext_seen <= 1'b0;
      else if (is_mrs && ba_o[0])  ext_seen <= 1'b1;
    end
  end

  AST_BA1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_o[1] == 1'b0); // R12
  AST_BASE_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && !ba_o[0]) |-> (addr_o[12:9] == 4'd0 && !addr_o[7])); // R6
  AST_EXT_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o[0]) |-> (addr_o[12:2] == 11'd0)); // R7
  AST_TRP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o[0]) |-> (since_pre >= TRP_EFF)); // R4
  AST_EXT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && !ba_o[0]) |-> ext_seen); // R3
  AST_TMRD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> is_nop); // R5
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R9
  AST_DONE_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o)); // R9
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (is_nop && !busy_o)); // R8
endmodule

bind ddr_mrs_seq ddr_mrs_seq_chk #(.TRP_CYC(TRP_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .cs_no  (cs_no),
  .ras_no (ras_no),
  .cas_no (cas_no),
  .we_no  (we_no),
  .ba_o   (ba_o),
  .addr_o (addr_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/ddr_mrs_seq_tb.sv
module ddr_mrs_seq_tb;
  localparam int TRP  = 2;
  localparam int TMRD = 1;          // below floor, effective 2
  localparam int M    = 2;
  localparam int K_EXT  = 1 + TRP;
  localparam int K_BASE = K_EXT + M;
  localparam int K_DONE = K_BASE + M;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  cas_half_i = '0;
  logic [3:0]  burst_len_i = '0;
  logic        interleave_i = 1'b0, dll_reset_i = 1'b0, dll_disable_i = 1'b0, half_drive_i = 1'b0;
  logic        cs_no, ras_no, cas_no, we_no;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;
  logic        busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  ddr_mrs_seq #(.TRP_CYC(TRP), .TMRD_CYC(TMRD)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .cas_half_i(cas_half_i), .burst_len_i(burst_len_i),
    .interleave_i(interleave_i), .dll_reset_i(dll_reset_i),
    .dll_disable_i(dll_disable_i), .half_drive_i(half_drive_i),
    .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
    .ba_o(ba_o), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // {cmd[3:0], ba[1:0], addr[12:0], busy, done, err}
  function automatic logic [21:0] pack(logic [3:0] c, logic [1:0] b, logic [12:0] a,
                                       logic bs, logic dn, logic er);
    return {c, b, a, bs, dn, er};
  endfunction

  function automatic logic [21:0] observed();
    return {cs_no, ras_no, cas_no, we_no, ba_o, addr_o, busy_o, done_o, err_o};
  endfunction

  task automatic check(string tag, logic [21:0] act, logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(logic [2:0] cl, logic [3:0] bl, logic il, logic dr, logic dd, logic hd);
    logic        legal;
    logic [2:0]  clc, blc;
    logic [12:0] bw, ew, pa;
    legal = (cl inside {3'd4, 3'd5, 3'd6}) && (bl inside {4'd2, 4'd4, 4'd8});
    clc = (cl == 3'd5) ? 3'd6 : 3'(cl / 2);
    blc = 3'($clog2(bl));
    bw = {4'b0, dr, 1'b0, clc, il, blc};
    ew = {11'b0, hd, dd};
    pa = 13'h0400;
    @(negedge clk_i);
    cas_half_i = cl; burst_len_i = bl; interleave_i = il;
    dll_reset_i = dr; dll_disable_i = dd; half_drive_i = hd;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (!legal) begin
      for (int k = 1; k <= 3; k++) begin
        check("R8 illegal config", observed(), pack(4'b0111, 2'b00, 13'h0, 1'b0, 1'b0, 1'b1));
        @(negedge clk_i);
      end
    end else begin
      for (int k = 1; k <= K_DONE + 2; k++) begin
        if (k == 1)
          check("R2 precharge, R8 err cleared, R9 done dropped", observed(),
                pack(4'b0010, 2'b00, pa, 1'b1, 1'b0, 1'b0));
        else if (k == K_EXT)
          check("R4 R7 R11 extended write", observed(),
                pack(4'b0000, 2'b01, ew, 1'b1, 1'b0, 1'b0));
        else if (k == K_BASE)
          check("R3 R5 R6 R11 base write", observed(),
                pack(4'b0000, 2'b00, bw, 1'b1, 1'b0, 1'b0));
        else if (k >= K_DONE)
          check("R5 R9 done level", observed(),
                pack(4'b0111, 2'b00, 13'h0, 1'b0, 1'b1, 1'b0));
        else
          check("R10 R12 nop gap", observed(),
                pack(4'b0111, 2'b00, 13'h0, 1'b1, 1'b0, 1'b0));
        if (k == 2) begin
          start_i = 1'b1;
          cas_half_i = 3'd7; burst_len_i = 4'd0;
          interleave_i = ~il; dll_reset_i = ~dr; dll_disable_i = ~dd; half_drive_i = ~hd;
        end
        if (k == 3) start_i = 1'b0;
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset state", observed(), pack(4'b0111, 2'b00, 13'h0, 1'b0, 1'b0, 1'b0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", observed(), pack(4'b0111, 2'b00, 13'h0, 1'b0, 1'b0, 1'b0));
    for (int i = 0; i < 512; i++) begin
      run(3'(i), 4'(i >> 3), i[7], i[0] ^ i[8], i[1] ^ i[8], i[2] ^ i[7]);
    end
    run(3'd5, 4'd8, 1'b1, 1'b1, 1'b1, 1'b1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule